// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is the bit-level engine of a two-wire serial target. Slow control logic next to it does the protocol work: address matching, command decoding and byte buffering. The block synchronises the clock and data lines and detects a start condition. It moves bits through a single 8-bit shift register and counts clock edges against a limit that the control logic sets. When the limit is reached it raises a flag and holds the clock low, so the control logic can respond at its own pace.

One register serves both directions. Bit 7 is presented on the data line at every falling clock edge, and the sampled line is shifted into bit 0 at every rising edge. Both lines are open-drain: the block only ever pulls them low, and reads them back through separate inputs. Because of this, a byte preloaded into the register can send and receive in the same pass. With the right pattern, one 4-edge pass both samples the read/write bit and drives the acknowledge.

The control logic works through strobes. It loads or reads the data register, presets the edge count, and clears the start and overflow flags. It reads the synchronised clock level to decide whether the address phase needs 14 or 15 edges.

Top module: `tw_shift_unit`

## Requirements
- R1: The start flag sets when the synchronised data line falls while the synchronised clock is high. A fall of the data line while the clock is low leaves the flag clear. `clr_start` clears the flag.
- R2: While the start flag is set, the block holds the clock line low (`scl_pull_o`=1) from the next falling clock edge on. The hold ends once the flag is cleared, unless the overflow flag is set.
- R3: The edge counter counts every rising and every falling edge of the clock. After a preset of N (1..16), the overflow flag sets on exactly the N-th following edge and not before. `clr_ovf` clears it.
- R4: A preset value of 0, or of 17 to 31, on the 5-bit `count_preset` acts as 16.
- R5: On each rising clock edge, the sampled data line shifts into bit 0 of the data register and the other bits move up by one. A load through `wr_data` replaces the whole register.
- R6: On each falling clock edge, bit 7 is latched to the data line. A load made while the clock is low latches its bit 7 at once. The line is pulled low only when `sda_drive_en`=1 and the latched bit is 0, so a 1 releases the line and another device's low level is read back as 0.
- R7: While the overflow flag is set, the clock line is held low from its next falling edge until the flag is cleared.
- R8: With 0xFF loaded after a start, and a preset of 15 (clock still high) or 14 (clock already low), the overflow fires at the falling edge after the 7th address bit. The register then reads 0x80 OR the 7-bit address, most significant bit first.
- R9: After an address capture, loading 0xBF with a preset of 4 does three things. It drives the data line low during the 9th clock, leaves bit 1 equal to the read/write bit (register value 0xFC OR rw<<1), and releases the line after the final falling edge.
- R10: An edge that arrives in the same cycle as a preset write is counted on top of the preset.
- R11: After reset both flags are 0, neither line is pulled, and the data register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed clock line level |
| sda_i | input | 1 | Sensed data line level |
| scl_pull_o | output | 1 | 1 pulls the clock line low |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| sda_drive_en | input | 1 | Lets the latched bit drive the data line |
| wr_data | input | 1 | Load strobe for the data register |
| wdata | input | 8 | Value loaded into the data register |
| rdata | output | 8 | Current data register contents |
| wr_count | input | 1 | Preset strobe for the edge counter |
| count_preset | input | 5 | Number of edges until overflow |
| clr_start | input | 1 | Clears the start flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| start_flag | output | 1 | Start condition seen |
| ovf_flag | output | 1 | Edge limit reached |
| scl_level | output | 1 | Synchronised clock line level |

## Verification
The hardest case to reach from the ports is the race in R10. A preset write has to land in the very cycle in which the synchroniser reports a falling clock edge. The bench gets there by counting flops: it drives the clock line low at a falling system edge and raises `wr_count` exactly two system cycles later. That places the strobe in the same cycle as the detected edge. An address capture is then started with a preset of 15, and the overflow must appear after the 7th address bit rather than one edge later. The bench also builds the stretched-clock paths on purpose: its controller model releases the clock and then waits until the line is actually high.

// File: rtl/tw_shift_unit.sv
module tw_shift_unit #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  input  logic          sda_drive_en,
  input  logic          wr_data,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          wr_count,
  input  logic [CW:0]   count_preset,
  input  logic          clr_start,
  input  logic          clr_ovf,
  output logic          start_flag,
  output logic          ovf_flag,
  output logic          scl_level
);
  localparam int LIMIT = 1 << CW;

  logic [1:0]    scl_sync, sda_sync;
  logic          scl_d, sda_d;
  logic          scl_now, sda_now;
  logic          scl_rise, scl_fall, any_edge, start_det;
  logic [CW-1:0] cnt;
  logic [CW:0]   preset_eff, base, sum;
  logic          ovf_set, start_nx, ovf_nx, hold, hold_nx;
  logic [DW-1:0] sreg;
  logic          lat;

  assign scl_now   = scl_sync[1];
  assign sda_now   = sda_sync[1];
  assign scl_rise  = scl_now & ~scl_d;
  assign scl_fall  = ~scl_now & scl_d;
  assign any_edge  = scl_rise | scl_fall;
  assign start_det = scl_now & scl_d & sda_d & ~sda_now;
  assign scl_level = scl_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_now;
      sda_d    <= sda_now;
    end
  end

  always_comb begin
    if (count_preset == '0 || count_preset > (CW+1)'(LIMIT))
      preset_eff = (CW+1)'(LIMIT);
    else
      preset_eff = count_preset;
  end

  assign base     = (CW+1)'(LIMIT) - preset_eff;
  assign sum      = (wr_count ? base : {1'b0, cnt}) + {{CW{1'b0}}, any_edge};
  assign ovf_set  = sum[CW];
  assign start_nx = start_det | (start_flag & ~clr_start);
  assign ovf_nx   = ovf_set | (ovf_flag & ~clr_ovf);
  assign hold_nx  = ((scl_fall & (start_flag | ovf_flag | ovf_set)) | hold)
                    & (start_nx | ovf_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      start_flag <= 1'b0;
      ovf_flag   <= 1'b0;
      hold       <= 1'b0;
    end else begin
      cnt        <= sum[CW-1:0];
      start_flag <= start_nx;
      ovf_flag   <= ovf_nx;
      hold       <= hold_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      lat  <= 1'b1;
    end else begin
      if (wr_data)       sreg <= wdata;
      else if (scl_rise) sreg <= {sreg[DW-2:0], sda_now};
      if (wr_data && !scl_now) lat <= wdata[DW-1];
      else if (scl_fall)       lat <= sreg[DW-1];
    end
  end

  assign rdata      = sreg;
  assign scl_pull_o = hold;
  assign sda_pull_o = sda_drive_en & ~lat;

  assert_start_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag && scl_fall && !clr_start) |=> scl_pull_o);

  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_flag) && !ovf_flag) |-> !scl_pull_o);

  assert_ovf_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(scl_rise || scl_fall));

  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && scl_fall && !clr_ovf) |=> scl_pull_o);

  assert_sda_quiet_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_now) && $stable(sda_drive_en)) |-> $stable(sda_pull_o));
endmodule

// File: tb/tw_shift_unit_test.sv
module tw_shift_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_ctl = 1'b1, sda_ctl = 1'b1;
  logic sda_drive_en = 1'b0, wr_data = 1'b0, wr_count = 1'b0;
  logic clr_start = 1'b0, clr_ovf = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [4:0] count_preset = 5'd0;
  logic scl_pull_o, sda_pull_o, start_flag, ovf_flag, scl_level;
  logic [7:0] rdata;
  logic bus_scl, bus_sda, last_sda;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;
  assign bus_scl = scl_ctl & ~scl_pull_o;
  assign bus_sda = sda_ctl & ~sda_pull_o;

  tw_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .sda_drive_en(sda_drive_en),
    .wr_data(wr_data), .wdata(wdata), .rdata(rdata), .wr_count(wr_count),
    .count_preset(count_preset), .clr_start(clr_start), .clr_ovf(clr_ovf),
    .start_flag(start_flag), .ovf_flag(ovf_flag), .scl_level(scl_level));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_data(logic [7:0] v);
    wdata = v; wr_data = 1'b1; @(negedge clk); wr_data = 1'b0;
  endtask

  task automatic load_count(logic [4:0] n);
    count_preset = n; wr_count = 1'b1; @(negedge clk); wr_count = 1'b0;
  endtask

  task automatic do_clr_start();
    clr_start = 1'b1; @(negedge clk); clr_start = 1'b0;
  endtask

  task automatic do_clr_ovf();
    clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
  endtask

  task automatic wait_high();
    for (int i = 0; i < 400 && !bus_scl; i++) @(negedge clk);
  endtask

  task automatic finish_pulse();
    wait_high(); cyc(6);
    last_sda = bus_sda;
    scl_ctl = 1'b0; cyc(6);
  endtask

  task automatic clk_pulse(logic b);
    sda_ctl = b; cyc(3);
    scl_ctl = 1'b1;
    finish_pulse();
  endtask

  task automatic check_held(logic nb, string tag);
    sda_ctl = nb; cyc(3);
    scl_ctl = 1'b1; cyc(20);
    chk(tag, {7'd0, bus_scl}, 8'd0);
  endtask

  task automatic do_start();
    sda_ctl = 1'b1; scl_ctl = 1'b1; wait_high(); cyc(6);
    sda_ctl = 1'b0; cyc(6);
    chk("R1 start flag after SDA fall with SCL high", {7'd0, start_flag}, 8'd1);
  endtask

  task automatic t_reset();
    chk("R11 reset start_flag", {7'd0, start_flag}, 8'd0);
    chk("R11 reset ovf_flag", {7'd0, ovf_flag}, 8'd0);
    chk("R11 reset scl_pull", {7'd0, scl_pull_o}, 8'd0);
    chk("R11 reset sda_pull", {7'd0, sda_pull_o}, 8'd0);
    chk("R11 reset rdata", rdata, 8'h00);
  endtask

  task automatic t_no_start_low();
    scl_ctl = 1'b0; cyc(6);
    sda_ctl = 1'b0; cyc(6);
    chk("R1 no start when SCL low", {7'd0, start_flag}, 8'd0);
    sda_ctl = 1'b1; cyc(6);
  endtask

  task automatic t_addr(int mode, logic [6:0] addr, string tag);
    do_start();
    if (mode == 0) begin
      scl_ctl = 1'b0; cyc(8);
      check_held(addr[6], "R2 SCL held after start fall");
      chk("R2 scl_level low while held", {7'd0, scl_level}, 8'd0);
      load_data(8'hFF); load_count(5'd14); do_clr_start();
      cyc(4);
      chk("R2 SCL released after clr_start", {7'd0, bus_scl}, 8'd1);
      finish_pulse();
      for (int i = 5; i >= 0; i--) clk_pulse(addr[i]);
    end else if (mode == 1) begin
      load_data(8'hFF); load_count(5'd15); do_clr_start();
      scl_ctl = 1'b0; cyc(6);
      chk("R2 no hold when start cleared before fall", {7'd0, scl_pull_o}, 8'd0);
      for (int i = 6; i >= 0; i--) clk_pulse(addr[i]);
    end else begin
      load_data(8'hFF); do_clr_start();
      scl_ctl = 1'b0;
      cyc(2);
      count_preset = 5'd15; wr_count = 1'b1; @(negedge clk); wr_count = 1'b0;
      cyc(4);
      for (int i = 6; i >= 0; i--) begin
        if (i == 0) chk("R10 no overflow before 7th bit", {7'd0, ovf_flag}, 8'd0);
        clk_pulse(addr[i]);
      end
    end
    chk({tag, " overflow after 7 address bits"}, {7'd0, ovf_flag}, 8'd1);
    chk({tag, " address in register"}, rdata, {1'b1, addr});
  endtask

  task automatic t_ack_rw(logic rw);
    check_held(rw, "R7 SCL held while overflow set");
    sda_drive_en = 1'b1;
    load_data(8'hBF); load_count(5'd4); do_clr_ovf();
    finish_pulse();
    chk("R9 rw bit read from line", {7'd0, last_sda}, {7'd0, rw});
    clk_pulse(1'b1);
    chk("R9 ack driven low in 9th clock", {7'd0, last_sda}, 8'd0);
    chk("R9 overflow after 4 edges", {7'd0, ovf_flag}, 8'd1);
    chk("R9 rw bit in bit 1", rdata, 8'hFC | {6'd0, rw, 1'b0});
    chk("R9 SDA released after ack", {7'd0, bus_sda}, 8'd1);
  endtask

  task automatic t_send_byte(logic [7:0] v);
    logic [7:0] seen;
    check_held(1'b1, "R7 SCL held before send");
    load_data(v); load_count(5'd16); do_clr_ovf();
    finish_pulse();
    seen[7] = last_sda;
    for (int i = 6; i >= 0; i--) begin
      clk_pulse(1'b1);
      seen[i] = last_sda;
    end
    chk("R6 byte presented MSB first", seen, v);
    chk("R5 read-back of own bits", rdata, v);
    chk("R3 overflow after 16 edges", {7'd0, ovf_flag}, 8'd1);
    check_held(1'b0, "R7 SCL held before ack receive");
    sda_drive_en = 1'b0;
    load_count(5'd2); do_clr_ovf();
    finish_pulse();
    chk("R5 controller ack shifted into bit 0", rdata, {v[6:0], 1'b0});
    chk("R3 overflow after 2 edges", {7'd0, ovf_flag}, 8'd1);
  endtask

  task automatic t_clamp(logic [4:0] p, string tag);
    check_held(1'b1, "R7 SCL held before clamp test");
    load_count(p); do_clr_ovf();
    finish_pulse();
    for (int i = 0; i < 6; i++) clk_pulse(1'b1);
    scl_ctl = 1'b1; wait_high(); cyc(6);
    chk({tag, " no overflow after 15 edges"}, {7'd0, ovf_flag}, 8'd0);
    scl_ctl = 1'b0; cyc(6);
    chk({tag, " overflow at 16th edge"}, {7'd0, ovf_flag}, 8'd1);
  endtask

  task automatic t_odd_count();
    check_held(1'b1, "R7 SCL held before odd count");
    load_count(5'd3); do_clr_ovf();
    finish_pulse();
    chk("R3 no overflow after 2 of 3 edges", {7'd0, ovf_flag}, 8'd0);
    scl_ctl = 1'b1; wait_high(); cyc(6);
    chk("R3 overflow on 3rd edge (rising)", {7'd0, ovf_flag}, 8'd1);
    chk("R7 no hold while SCL high", {7'd0, scl_pull_o}, 8'd0);
    scl_ctl = 1'b0; cyc(6);
    check_held(1'b1, "R7 hold at falling edge after overflow");
    do_clr_ovf(); cyc(4);
    chk("R7 release after clr_ovf", {7'd0, bus_scl}, 8'd1);
  endtask

  task automatic end_txn();
    check_held(1'b0, "R7 SCL held at end of transfer");
    sda_drive_en = 1'b0;
    do_clr_ovf(); wait_high(); cyc(6);
    sda_ctl = 1'b1; cyc(6);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    cyc(4);
    t_reset();
    rst_n = 1'b1; cyc(4);
    t_no_start_low();
    t_addr(0, 7'h5A, "R8 held path preset 14");
    t_ack_rw(1'b1);
    t_send_byte(8'hA5);
    t_clamp(5'd0, "R4 preset 0");
    t_clamp(5'd20, "R4 preset 20");
    t_odd_count();
    scl_ctl = 1'b0; cyc(6);
    t_addr(1, 7'h13, "R8 early path preset 15");
    t_ack_rw(1'b0);
    end_txn();
    t_addr(2, 7'h2C, "R10 preset written with edge");
    end_txn();
    report();
    $finish;
  end
endmodule